// File: doc/BRIEF.md
# Shift Unit With Flags

This block is the shift stage of a 16-bit execution datapath. It handles three operations: logical shift left, logical shift right and arithmetic shift right. For each one it produces the shifted word together with a full set of status flags. It has exact, defined behaviour for counts that reach or pass the operand width, up to 31.

The issuing logic presents the following on the same cycle as a one-cycle `start_i` strobe:
- an operand word;
- a count byte;
- an operation select.

One clock later the block returns the registered result and flags, with a single-cycle `done_o`. Two update enables tell the write-back stage whether the destination and the flag register should change.

A masked count of zero completes with `done_o`, but leaves the result and flags untouched and keeps both enables low. Operand fetch, decode and write-back belong to the surrounding pipeline.

Top module: `shf_unit`

## Requirements
- R1: Only `count_i[4:0]` is used as the shift amount. Bits 7:5 of the count byte have no effect on any output.
- R2: When `start_i` is high and `count_i[4:0]` is zero, the next cycle shows `result_o` and all flag outputs unchanged from their previous values. `res_we_o` and `flag_we_o` stay low and `done_o` is high.
- R3: For a left shift with amount n in 1..16:
  - the result is the operand shifted left by n with zeros entering;
  - `cf_o` is operand bit 16−n;
  - `of_o` is `cf_o` XOR result bit 15.
- R4: For a left shift with amount n in 17..31, the result, `cf_o` and `of_o` are all zero.
- R5: For a logical right shift with amount n:
  - zeros enter from the top;
  - `cf_o` is operand bit n−1, or zero when n−1 exceeds 15;
  - `of_o` is result bit 15 XOR result bit 14.
- R6: For an arithmetic right shift with amount n:
  - copies of operand bit 15 enter from the top;
  - `cf_o` is bit n−1 of the sign-extended operand;
  - `of_o` is 0.
- R7: `sf_o` equals result bit 15. `zf_o` is 1 exactly when the result is zero. `pf_o` is 1 when result bits 7:0 hold an even number of ones. `af_o` is 0.
- R8: Outputs change one clock after the `start_i` cycle. `done_o` is high for exactly the cycle after each `start_i` cycle. `res_we_o` and `flag_we_o` are high only together with `done_o`, and only for a nonzero amount.
- R9: During reset, all outputs are zero.
- R10: The operation select is decoded as follows:
  - bit 1 is the direction (0 = left, 1 = right);
  - bit 0 selects sign fill for a right shift;
  - bit 0 is ignored for a left shift, so 2'b00 and 2'b01 are both logical left, 2'b10 is logical right and 2'b11 is arithmetic right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation strobe, one cycle per operation |
| op_i | input | 2 | Operation select (bit 1 right, bit 0 sign fill) |
| operand_i | input | 16 | Word to shift |
| count_i | input | 8 | Shift count byte, low 5 bits used |
| result_o | output | 16 | Registered shifted word |
| cf_o | output | 1 | Carry: last bit shifted out |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Even parity of result low byte |
| af_o | output | 1 | Auxiliary carry, always cleared |
| res_we_o | output | 1 | Destination update enable |
| flag_we_o | output | 1 | Flag register update enable |
| done_o | output | 1 | Completion strobe |

## Verification
Every output is a register loaded from the inputs of a single start cycle. A wrong shift stage or carry tap therefore shows on `result_o` or `cf_o` in the very next cycle, for the first count whose bit selects that stage. Faults in the hold path behave differently: a write enable left set on a zero count, or a result register loaded when it should hold, is only visible on the cycle after such a count. The bench therefore runs zero counts between nonzero ones, so that a stale or overwritten value is caught on that cycle. Because the reference model is compared on every clock, a stray `done_o` or enable pulse during idle cycles is caught the cycle it appears.

// File: rtl/shf_pkg.sv
package shf_pkg;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned CNT_W  = 8;

  typedef enum logic [1:0] {
    OP_SHL     = 2'b00,
    OP_SHL_ALT = 2'b01,
    OP_SHR     = 2'b10,
    OP_SAR     = 2'b11
  } shf_op_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic pf;
    logic af;
  } shf_flags_t;
endpackage

// File: rtl/shf_count_dec.sv
module shf_count_dec #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned AMT_W = $clog2(DATA_W) + 1
) (
  input  logic [CNT_W-1:0] count_i,
  output logic [AMT_W-1:0] amt_o,
  output logic             zero_o
);
  // upper count bits are architecturally ignored
  logic unused_hi;
  assign unused_hi = ^count_i[CNT_W-1:AMT_W];

  assign amt_o  = count_i[AMT_W-1:0];
  assign zero_o = (amt_o == '0);
endmodule

// File: rtl/shf_core.sv
module shf_core #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned AMT_W = $clog2(DATA_W) + 1,
  localparam int unsigned EXT_W = DATA_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              right_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  // extended word: one guard bit catches the last bit shifted out
  logic [EXT_W-1:0] stg [AMT_W+1];
  logic             fill;

  assign fill   = right_i & arith_i & data_i[DATA_W-1];
  assign stg[0] = right_i ? {data_i, 1'b0} : {1'b0, data_i};

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    logic [EXT_W-1:0] sh_l, sh_r;
    if (SH < EXT_W) begin : g_part
      assign sh_l = {stg[s][EXT_W-1-SH:0], {SH{1'b0}}};
      assign sh_r = {{SH{fill}}, stg[s][EXT_W-1:SH]};
    end else begin : g_full
      assign sh_l = '0;
      assign sh_r = {EXT_W{fill}};
    end
    assign stg[s+1] = !amt_i[s] ? stg[s] : (right_i ? sh_r : sh_l);
  end

  assign res_o   = right_i ? stg[AMT_W][EXT_W-1:1] : stg[AMT_W][DATA_W-1:0];
  assign carry_o = right_i ? stg[AMT_W][0] : stg[AMT_W][DATA_W];
endmodule

// File: rtl/shf_flag_gen.sv
module shf_flag_gen
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              right_i,
  input  logic              arith_i,
  output shf_flags_t        flags_o
);
  logic ovf;

  always_comb begin
    if (!right_i)     ovf = carry_i ^ res_i[DATA_W-1];
    else if (arith_i) ovf = 1'b0;
    else              ovf = res_i[DATA_W-1] ^ res_i[DATA_W-2];
  end

  assign flags_o.cf = carry_i;
  assign flags_o.of = ovf;
  assign flags_o.sf = res_i[DATA_W-1];
  assign flags_o.zf = (res_i == '0);
  assign flags_o.pf = ~^res_i[7:0];
  assign flags_o.af = 1'b0;
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int unsigned DW = shf_pkg::DATA_W,
  parameter int unsigned CW = shf_pkg::CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] operand_i,
  input  logic [CW-1:0] count_i,
  output logic [DW-1:0] result_o,
  output logic          cf_o,
  output logic          of_o,
  output logic          sf_o,
  output logic          zf_o,
  output logic          pf_o,
  output logic          af_o,
  output logic          res_we_o,
  output logic          flag_we_o,
  output logic          done_o
);
  localparam int unsigned AMT_W = $clog2(DW) + 1;

  logic [AMT_W-1:0] amt;
  logic             amt_zero;
  logic [DW-1:0]    res_d;
  logic             carry_d;
  shf_flags_t       flags_d, flags_q;
  logic [DW-1:0]    res_q;
  logic             we_q, done_q;

  shf_count_dec #(.DATA_W(DW), .CNT_W(CW)) u_dec (
    .count_i (count_i),
    .amt_o   (amt),
    .zero_o  (amt_zero)
  );

  shf_core #(.DATA_W(DW)) u_core (
    .data_i  (operand_i),
    .amt_i   (amt),
    .right_i (op_i[1]),
    .arith_i (op_i[0]),
    .res_o   (res_d),
    .carry_o (carry_d)
  );

  shf_flag_gen #(.DATA_W(DW)) u_flags (
    .res_i   (res_d),
    .carry_i (carry_d),
    .right_i (op_i[1]),
    .arith_i (op_i[0]),
    .flags_o (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      flags_q <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= start_i;
      we_q   <= start_i & ~amt_zero;
      if (start_i && !amt_zero) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign result_o  = res_q;
  assign cf_o      = flags_q.cf;
  assign of_o      = flags_q.of;
  assign sf_o      = flags_q.sf;
  assign zf_o      = flags_q.zf;
  assign pf_o      = flags_q.pf;
  assign af_o      = flags_q.af;
  assign res_we_o  = we_q;
  assign flag_we_o = we_q;
  assign done_o    = done_q;
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [1:0]    op_i,
  input logic [CW-1:0] count_i,
  input logic [DW-1:0] result_o,
  input logic          cf_o,
  input logic          of_o,
  input logic          sf_o,
  input logic          zf_o,
  input logic          res_we_o,
  input logic          flag_we_o,
  input logic          done_o
);
  localparam int unsigned AMT_W = $clog2(DW) + 1;

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R8
  AST_NO_STRAY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o); // R8
  AST_WE_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_o || flag_we_o) |-> done_o); // R8
  AST_ZERO_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && count_i[AMT_W-1:0] == '0) |=> ($stable(result_o) && $stable(cf_o) && !res_we_o)); // R2
  AST_BIG_LEFT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op_i[1] && count_i[AMT_W-1:0] > AMT_W'(DW)) |=> (result_o == '0 && !cf_o && !of_o)); // R4
  AST_SAR_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 2'b11 && count_i[AMT_W-1:0] != '0) |=> !of_o); // R6
  AST_ZF_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (zf_o == (result_o == '0) && sf_o == result_o[DW-1])); // R7
endmodule

bind shf_unit shf_unit_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .op_i      (op_i),
  .count_i   (count_i),
  .result_o  (result_o),
  .cf_o      (cf_o),
  .of_o      (of_o),
  .sf_o      (sf_o),
  .zf_o      (zf_o),
  .res_we_o  (res_we_o),
  .flag_we_o (flag_we_o),
  .done_o    (done_o)
);

// File: tb/sim_shf_unit.sv
module sim_shf_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [15:0] operand = '0;
  logic [7:0]  count = '0;
  logic [15:0] result;
  logic cf, of, sf, zf, pf, af, res_we, flag_we, done;

  int checks = 0;
  int fails  = 0;

  logic [15:0] e_res = '0;
  logic [5:0]  e_flg = '0;  // {cf,of,sf,zf,pf,af}
  logic        e_done = 1'b0, e_we = 1'b0;
  string       cur_tag = "R9";

  always #5 clk = ~clk;

  shf_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op_sel),
    .operand_i(operand), .count_i(count), .result_o(result),
    .cf_o(cf), .of_o(of), .sf_o(sf), .zf_o(zf), .pf_o(pf), .af_o(af),
    .res_we_o(res_we), .flag_we_o(flag_we), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare();
    chk({cur_tag, " result"}, 32'(result), 32'(e_res));
    chk({cur_tag, " flags R7"}, 32'({cf, of, sf, zf, pf, af}), 32'(e_flg));
    chk({cur_tag, " strobes R8"}, 32'({done, res_we, flag_we}), 32'({e_done, e_we, e_we}));
  endtask

  // reference model: behavioural, integer arithmetic
  task automatic model(input logic s, input logic [1:0] op, input logic [15:0] a, input logic [7:0] c);
    int ci;
    int sv;
    logic [15:0] r;
    logic cfv, ofv;
    ci = int'(c[4:0]);
    e_done = s;
    e_we = s && (ci != 0);
    if (!e_we) return;
    cfv = 1'b0;
    if (!op[1]) begin
      r = 16'(32'(a) << ci);
      if (ci <= 16) cfv = a[16-ci];
      ofv = cfv ^ r[15];
    end else if (!op[0]) begin
      r = 16'(32'(a) >> ci);
      if (ci <= 16) cfv = a[ci-1];
      ofv = r[15] ^ r[14];
    end else begin
      sv = int'($signed(a));
      r = 16'(sv >>> ci);
      cfv = 1'((sv >>> (ci - 1)) & 1);
      ofv = 1'b0;
    end
    e_res = r;
    e_flg = {cfv, ofv, r[15], (r == 16'h0), ~^r[7:0], 1'b0};
  endtask

  task automatic cyc(input logic s, input logic [1:0] op, input logic [15:0] a,
                     input logic [7:0] c, input string tag);
    @(negedge clk);
    compare();
    start = s; op_sel = op; operand = a; count = c;
    model(s, op, a, c);
    cur_tag = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog: got no completion expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", 32'({result, cf, of, sf, zf, pf, af, res_we, flag_we, done}), 32'h0);
    rst_n = 1'b1;
    // R3 left within width
    cyc(1, 2'b00, 16'h8001, 8'd1,  "R3 shl1");
    cyc(1, 2'b00, 16'h4001, 8'd1,  "R3 shl1 of");
    cyc(1, 2'b00, 16'h0001, 8'd16, "R3 shl16");
    cyc(1, 2'b00, 16'h1234, 8'd4,  "R3 shl4");
    // R4 left beyond width
    cyc(1, 2'b00, 16'hFFFF, 8'd17, "R4 shl17");
    cyc(1, 2'b00, 16'hFFFF, 8'd31, "R4 shl31");
    // R2 zero count holds previous state
    cyc(1, 2'b00, 16'h5555, 8'd3,  "R2 setup");
    cyc(1, 2'b10, 16'hFFFF, 8'h20, "R2 zero hold");
    cyc(1, 2'b11, 16'h8000, 8'h00, "R2 zero hold again");
    cyc(0, 2'b00, 16'h0000, 8'h00, "R8 idle");
    // R1 upper count bits ignored
    cyc(1, 2'b00, 16'h00F1, 8'hE3, "R1 masked shl3");
    cyc(1, 2'b10, 16'hF000, 8'hA4, "R1 masked shr4");
    // R5 logical right
    cyc(1, 2'b10, 16'h8001, 8'd1,  "R5 shr1");
    cyc(1, 2'b10, 16'hC000, 8'd2,  "R5 shr2");
    cyc(1, 2'b10, 16'h8000, 8'd16, "R5 shr16");
    cyc(1, 2'b10, 16'hFFFF, 8'd17, "R5 shr17");
    cyc(1, 2'b10, 16'hFFFF, 8'd31, "R5 shr31");
    // R6 arithmetic right
    cyc(1, 2'b11, 16'h8000, 8'd1,  "R6 sar1");
    cyc(1, 2'b11, 16'h8001, 8'd15, "R6 sar15");
    cyc(1, 2'b11, 16'h8000, 8'd16, "R6 sar16");
    cyc(1, 2'b11, 16'h9000, 8'd20, "R6 sar20");
    cyc(1, 2'b11, 16'h7FFF, 8'd31, "R6 sar31 pos");
    // R10 bit0 ignored for left
    cyc(1, 2'b01, 16'h8421, 8'd5,  "R10 alt left");
    cyc(1, 2'b01, 16'h0003, 8'd20, "R10 alt left big");
    // R7 parity / zero
    cyc(1, 2'b10, 16'h0300, 8'd8,  "R7 even parity");
    cyc(1, 2'b10, 16'h0100, 8'd8,  "R7 odd parity");
    cyc(1, 2'b00, 16'h8000, 8'd1,  "R7 zero result");
    cyc(0, 2'b00, 16'h0000, 8'd0,  "R8 idle");
    cyc(0, 2'b11, 16'hFFFF, 8'd5,  "R8 idle no start");
    // mixed stream with idles and zero counts
    for (int i = 0; i < 600; i++) begin
      logic [1:0] op;
      op = 2'($urandom);
      cyc(1'($urandom_range(0, 3) != 0), op, 16'($urandom),
          (i % 7 == 0) ? {3'($urandom), 5'd0} : 8'($urandom),
          op[1] ? (op[0] ? "R6 mix" : "R5 mix") : "R3 R4 mix");
    end
    cyc(0, 2'b00, 16'h0, 8'h0, "R8 drain");
    @(negedge clk);
    compare();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule